// File: doc/BRIEF.md
# Striped Parity Array Mapper

This block places logical strips on an array of `N` member disks and produces the redundancy word for each stripe row. Its address side takes a logical strip number and a layout mode. One clock later it reports the stripe row, the member that holds the strip, and the member that holds parity for that row. The layout mode is one of three: plain striping with no redundancy, a fixed parity member, or a parity member that moves by one on every row.

The data side is a word-serial stream with a valid/ready handshake. For each row it accepts `N-1` words, XORs them together and offers the result on an output stream. The result is tagged with the row it belongs to and the member it is destined for. When the words of a row are the data words, the result is the parity word.

The same engine also rebuilds a lost member. With the degraded flag set, the caller feeds the surviving data words plus the parity word. The XOR result is then the content of the missing member, and it is tagged with the failed-member index instead of the parity member.

Top module: `stripe_parity_mapper`

## Requirements
- R1: With mode 2'b00 (no redundancy), or the reserved code 2'b11, strip `s` maps to row `s / N` and member `s % N`. The has-parity output is 0 and the parity index is 0.
- R2: With mode 2'b01 (fixed parity), strip `s` maps to row `s / (N-1)` and member `s % (N-1)`. The parity member is `N-1` for every row and has-parity is 1.
- R3: With mode 2'b10 (moving parity), row `r = s / (N-1)` has its parity on member `(N-1) - (r % N)`. The data position `s % (N-1)` fills the other members in ascending order, skipping the parity member.
- R4: The mapping outputs are registered. They reflect the strip and mode present at the previous rising clock edge and are all zero after reset.
- R5: In a parity mode, the engine XORs the `N-1` words accepted for a row. After the last of those words it raises `out_valid_o` with that XOR on the next cycle. The accumulation starts afresh for each row.
- R6: In non-degraded operation, the result is tagged with the completed-row count since reset (starting at 0) on `out_row_o`. Its `out_member_o` is that row's parity member, computed as in R2 or R3 for the current mode.
- R7: With `degraded_i` high when a row completes, `out_member_o` equals `failed_i`. The output word is the XOR of the supplied survivors and parity, which equals the missing member's word.
- R8: While a result is offered and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_member_o` hold, and `in_ready_o` is low. The result is released on the cycle that `out_ready_i` is high.
- R9: In mode 2'b00 or 2'b11, input words are accepted (`in_ready_o` high) but produce no result and do not advance the row count.
- R10: After reset, `out_valid_o` is 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Layout mode: 00 none, 01 fixed parity, 10 moving parity, 11 as 00 |
| strip_i | input | LBA_W | Logical strip number to map |
| map_row_o | output | LBA_W | Stripe row of the mapped strip |
| map_member_o | output | MW | Member holding the mapped strip |
| map_parity_o | output | MW | Parity member of that row |
| map_has_parity_o | output | 1 | Mode in effect carries parity |
| degraded_i | input | 1 | Current row is a rebuild of a failed member |
| failed_i | input | MW | Index of the failed member |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Engine can take an input word |
| in_data_i | input | DW | Input word |
| out_valid_o | output | 1 | Result word offered |
| out_ready_i | input | 1 | Consumer takes the result |
| out_data_o | output | DW | Parity or rebuilt word |
| out_member_o | output | MW | Member the result belongs to |
| out_row_o | output | LBA_W | Row the result belongs to |

## Verification
Some properties are checked on every cycle. The registered mapping must name a member inside the array and must never place a data strip on the row's parity member. A held result must stay still under backpressure. No result may appear while the mode carries no parity.

Other behaviour can only be shown by the bench scenarios. These are the exact row and member arithmetic of each layout mode, the XOR value of each row, the rebuild of a dropped word from its survivors, and the row count that drives the moving parity position.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_DED  = 2'b01,
        MODE_ROT  = 2'b10,
        MODE_RSV  = 2'b11
    } mode_e;

    function automatic logic mode_has_parity(mode_e m);
        return (m == MODE_DED) || (m == MODE_ROT);
    endfunction

    // Parity member of a row: fixed at the top member, or moving down by one per row.
    function automatic int unsigned parity_slot(int unsigned row, int unsigned n, mode_e m);
        if (m == MODE_ROT) begin
            return (n - 1) - (row % n);
        end
        return n - 1;
    endfunction

endpackage

// File: rtl/spm_locator.sv
module spm_locator
    import spm_pkg::*;
#(
    parameter int unsigned N     = 5,
    parameter int unsigned LBA_W = 16,
    parameter int unsigned MW    = 3
) (
    input  logic [LBA_W-1:0] strip,
    input  mode_e            mode,
    output logic [LBA_W-1:0] row,
    output logic [MW-1:0]    member,
    output logic [MW-1:0]    parity,
    output logic             has_parity
);

    int unsigned s_w, per_w, row_w, pos_w, par_w, mem_w;

    always_comb begin
        s_w   = 32'(strip);
        per_w = mode_has_parity(mode) ? (N - 1) : N;
        row_w = s_w / per_w;
        pos_w = s_w % per_w;
        par_w = mode_has_parity(mode) ? parity_slot(row_w, N, mode) : 0;
        mem_w = ((mode == MODE_ROT) && (pos_w >= par_w)) ? pos_w + 1 : pos_w;
        row        = LBA_W'(row_w);
        member     = MW'(mem_w);
        parity     = MW'(par_w);
        has_parity = mode_has_parity(mode);
    end

endmodule

// File: rtl/spm_xor_engine.sv
module spm_xor_engine
    import spm_pkg::*;
#(
    parameter int unsigned N  = 5,
    parameter int unsigned DW = 32,
    parameter int unsigned RW = 16,
    parameter int unsigned MW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic          degraded,
    input  logic [MW-1:0] failed,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data,
    output logic [MW-1:0] out_member,
    output logic [RW-1:0] out_row
);

    localparam int unsigned LAST = N - 2;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [MW-1:0] cnt;
        logic          pend;
        logic [DW-1:0] res;
        logic [MW-1:0] mem;
        logic [RW-1:0] row;
        logic [RW-1:0] res_row;
    } eng_t;

    eng_t          eng_d, eng_q;
    logic [DW-1:0] fold_d;
    logic          par_on;

    assign par_on = mode_has_parity(mode);

    always_comb begin
        eng_d  = eng_q;
        fold_d = ((eng_q.cnt == '0) ? '0 : eng_q.acc) ^ in_data;
        if (eng_q.pend && out_ready) begin
            eng_d.pend = 1'b0;
        end
        if (in_valid && !eng_q.pend && par_on) begin
            if (eng_q.cnt == MW'(LAST)) begin
                eng_d.cnt     = '0;
                eng_d.pend    = 1'b1;
                eng_d.res     = fold_d;
                eng_d.res_row = eng_q.row;
                eng_d.row     = eng_q.row + 1'b1;
                eng_d.mem     = degraded ? failed
                                         : MW'(parity_slot(32'(eng_q.row), N, mode));
            end else begin
                eng_d.acc = fold_d;
                eng_d.cnt = eng_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign in_ready   = !eng_q.pend;
    assign out_valid  = eng_q.pend;
    assign out_data   = eng_q.res;
    assign out_member = eng_q.mem;
    assign out_row    = eng_q.res_row;

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_member))); // R8

    AST_NO_RESULT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!par_on && !out_valid) |=> !out_valid); // R9

    AST_MEMBER_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !degraded) |-> (32'(out_member) < N)); // R6

endmodule

// File: rtl/stripe_parity_mapper.sv
module stripe_parity_mapper
    import spm_pkg::*;
#(
    parameter int unsigned N     = 5,
    parameter int unsigned LBA_W = 16,
    parameter int unsigned DW    = 32,
    parameter int unsigned MW    = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [LBA_W-1:0] strip_i,
    output logic [LBA_W-1:0] map_row_o,
    output logic [MW-1:0]    map_member_o,
    output logic [MW-1:0]    map_parity_o,
    output logic             map_has_parity_o,
    input  logic             degraded_i,
    input  logic [MW-1:0]    failed_i,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [DW-1:0]    in_data_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [DW-1:0]    out_data_o,
    output logic [MW-1:0]    out_member_o,
    output logic [LBA_W-1:0] out_row_o
);

    typedef struct packed {
        logic [LBA_W-1:0] row;
        logic [MW-1:0]    member;
        logic [MW-1:0]    parity;
        logic             has_par;
    } map_t;

    mode_e mode_w;
    map_t  map_d, map_q;

    assign mode_w = mode_e'(mode_i);

    spm_locator #(.N(N), .LBA_W(LBA_W), .MW(MW)) loc_i (
        .strip      (strip_i),
        .mode       (mode_w),
        .row        (map_d.row),
        .member     (map_d.member),
        .parity     (map_d.parity),
        .has_parity (map_d.has_par)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign map_row_o        = map_q.row;
    assign map_member_o     = map_q.member;
    assign map_parity_o     = map_q.parity;
    assign map_has_parity_o = map_q.has_par;

    spm_xor_engine #(.N(N), .DW(DW), .RW(LBA_W), .MW(MW)) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_w),
        .degraded   (degraded_i),
        .failed     (failed_i),
        .in_valid   (in_valid_i),
        .in_ready   (in_ready_o),
        .in_data    (in_data_i),
        .out_valid  (out_valid_o),
        .out_ready  (out_ready_i),
        .out_data   (out_data_o),
        .out_member (out_member_o),
        .out_row    (out_row_o)
    );

    AST_MEMBER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(map_member_o) < N); // R1

    AST_DATA_OFF_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        map_has_parity_o |-> (map_member_o != map_parity_o)); // R3

    AST_PARITY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(map_parity_o) < N); // R2

endmodule

// File: tb/stripe_parity_mapper_tb.sv
`timescale 1ns/1ps
module stripe_parity_mapper_tb_top;

    localparam int unsigned N     = 5;
    localparam int unsigned LBA_W = 16;
    localparam int unsigned DW    = 32;
    localparam int unsigned MW    = $clog2(N);

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       mode_i;
    logic [LBA_W-1:0] strip_i;
    logic [LBA_W-1:0] map_row_o;
    logic [MW-1:0]    map_member_o;
    logic [MW-1:0]    map_parity_o;
    logic             map_has_parity_o;
    logic             degraded_i;
    logic [MW-1:0]    failed_i;
    logic             in_valid_i;
    logic             in_ready_o;
    logic [DW-1:0]    in_data_i;
    logic             out_valid_o;
    logic             out_ready_i;
    logic [DW-1:0]    out_data_o;
    logic [MW-1:0]    out_member_o;
    logic [LBA_W-1:0] out_row_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int rows_done = 0;

    always #2 clk = ~clk;

    stripe_parity_mapper #(.N(N), .LBA_W(LBA_W), .DW(DW)) dut_i (.*);

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit has_par(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    function automatic int exp_par(input logic [1:0] m, input int r);
        if (!has_par(m)) return 0;
        if (m == 2'b10) return (N - 1) - (r % N);
        return N - 1;
    endfunction

    function automatic int exp_row(input logic [1:0] m, input int s);
        return has_par(m) ? s / (N - 1) : s / N;
    endfunction

    function automatic int exp_mem(input logic [1:0] m, input int s);
        int per, pos, p;
        per = has_par(m) ? N - 1 : N;
        pos = s % per;
        p   = exp_par(m, s / per);
        if (m == 2'b10 && pos >= p) return pos + 1;
        return pos;
    endfunction

    task automatic check_map(input logic [1:0] m, input int s, input string tag);
        chk({tag, " row"},    map_row_o,        exp_row(m, s));
        chk({tag, " member"}, map_member_o,     exp_mem(m, s));
        chk({tag, " parity"}, map_parity_o,     exp_par(m, exp_row(m, s)));
        chk({tag, " haspar"}, map_has_parity_o, has_par(m));
    endtask

    task automatic map_one(input logic [1:0] m, input int s, input string tag);
        mode_i  = m;
        strip_i = LBA_W'(s);
        @(posedge clk); #1;
        check_map(m, s, tag);
    endtask

    task automatic send_word(input logic [DW-1:0] w);
        in_valid_i = 1'b1;
        in_data_i  = w;
        @(posedge clk); #1;
        in_valid_i = 1'b0;
    endtask

    // Feeds one row; deg selects rebuild of data position drop.
    task automatic do_row(input logic [1:0] m, input bit deg, input int drop, input int stall);
        logic [DW-1:0] w [0:7];
        logic [DW-1:0] par, expw;
        int exp_member;
        par = '0;
        for (int i = 0; i < N - 1; i++) begin
            w[i] = $urandom;
            par  = par ^ w[i];
        end
        mode_i     = m;
        degraded_i = deg;
        failed_i   = MW'($urandom % N);
        if (deg) begin
            expw       = w[drop];
            exp_member = failed_i;
            for (int i = 0; i < N - 1; i++) begin
                if (i != drop) send_word(w[i]);
            end
            send_word(par);
        end else begin
            expw       = par;
            exp_member = exp_par(m, rows_done);
            for (int i = 0; i < N - 1; i++) send_word(w[i]);
        end
        chk(deg ? "R7 valid" : "R5 valid", out_valid_o, 1);
        chk(deg ? "R7 data" : "R5 data", out_data_o, expw);
        chk(deg ? "R7 member" : "R6 member", out_member_o, exp_member);
        chk("R6 row", out_row_o, rows_done);
        for (int k = 0; k < stall; k++) begin
            @(posedge clk); #1;
            chk("R8 hold valid", out_valid_o, 1);
            chk("R8 hold data", out_data_o, expw);
            chk("R8 hold member", out_member_o, exp_member);
            chk("R8 in_ready low", in_ready_o, 0);
        end
        out_ready_i = 1'b1;
        @(posedge clk); #1;
        out_ready_i = 1'b0;
        chk("R8 released", out_valid_o, 0);
        chk("R8 ready again", in_ready_o, 1);
        rows_done++;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 1'b0; mode_i = 2'b00; strip_i = '0; degraded_i = 1'b0;
        failed_i = '0; in_valid_i = 1'b0; in_data_i = '0; out_ready_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 out_valid", out_valid_o, 0);
        chk("R10 in_ready", in_ready_o, 1);
        chk("R4 reset row", map_row_o, 0);
        chk("R4 reset member", map_member_o, 0);
        rst_n = 1'b1;

        // Directed mapping corners
        map_one(2'b00, 0, "R1 strip0");
        map_one(2'b00, N, "R1 strip N");
        map_one(2'b11, 7, "R1 reserved");
        map_one(2'b01, N - 2, "R2 last data");
        map_one(2'b01, N - 1, "R2 next row");
        map_one(2'b10, 0, "R3 row0");
        map_one(2'b10, (N - 1) * 3 + 2, "R3 row3");
        map_one(2'b10, 16'hFFFF, "R3 max strip");
        map_one(2'b01, 16'hFFFF, "R2 max strip");

        // R4: new strip not visible before the edge
        mode_i = 2'b00; strip_i = 16'd123;
        #0.5;
        chk("R4 before edge", map_row_o, exp_row(2'b01, 16'hFFFF));
        @(posedge clk); #1;
        check_map(2'b00, 123, "R4 after edge");

        // Random mapping in every mode
        for (int i = 0; i < 60; i++) begin
            logic [1:0] m;
            int s;
            m = 2'(i % 4);
            s = $urandom % 65536;
            map_one(m, s, (m == 2'b10) ? "R3 rand" : (m == 2'b01) ? "R2 rand" : "R1 rand");
        end

        // Stream: fixed parity then moving parity
        for (int i = 0; i < 3; i++) do_row(2'b01, 0, 0, 0);
        for (int i = 0; i < 2 * N; i++) do_row(2'b10, 0, 0, i % 3);

        // R9: plain mode takes words but produces nothing
        mode_i = 2'b00;
        for (int i = 0; i < 7; i++) begin
            chk("R9 in_ready", in_ready_o, 1);
            send_word($urandom);
            chk("R9 no result", out_valid_o, 0);
        end
        do_row(2'b01, 0, 0, 1);

        // R7: rebuild every data position
        for (int i = 0; i < N - 1; i++) do_row(2'b10, 1, i, 0);
        for (int i = 0; i < 6; i++) do_row(2'b01, 1, int'($urandom % (N - 1)), 2);
        do_row(2'b10, 0, 0, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule